// File: doc/BRIEF.md
# Prioritized Hardware Thread Scheduler with Counting Semaphores

This block decides which of up to eight hardware threads owns a single-issue control pipeline in each cycle. Each thread reports that it has work (`thr_ready`), that it is parked on an operation that gives the pipeline away (`thr_yield`), or that it is held up by a stall that does not give the pipeline away (`thr_hold`). The lowest-numbered eligible thread wins. A lower-numbered thread that becomes eligible displaces a higher-numbered one on the next clock edge. A thread keeps the pipeline while it is in a non-yielding stall, and during that stall no instruction issues.

A bank of counting semaphores lets software threads and hardware agents such as I/O engines synchronise with each other. A software thread may signal a semaphore or wait on it. A wait takes one unit if one is available. Otherwise the thread is parked, is no longer eligible, and is released when a later signal arrives. Hardware agents signal through their own ports. All signal sources that land on one semaphore in the same cycle add together. A count stops at its maximum, the surplus is discarded, and an error flag pulses.

The winning thread index is registered. The index output is what a pipeline would use to select its per-thread register bank.

Top module: `thread_sched`

## Requirements
- R1: While `rst_n` is low and on the first edge after its release, `sel_valid` is 0, `sel_thread` is 0 and `sig_ovf` is 0. Every semaphore count is 0 and no thread is parked.
- R2: A thread is eligible when its `thr_ready` bit is 1, its `thr_yield` bit is 0 and it is not parked on a semaphore. The selected thread is the eligible thread with the lowest index, and index 0 has the highest priority.
- R3: `sel_thread`, `sel_valid` and `sig_ovf` are registered. They show the result of the inputs present before a rising edge only after that edge.
- R4: When a higher-priority thread becomes eligible while a lower-priority thread is selected, `sel_thread` switches to the higher-priority thread on the next edge.
- R5: A thread with `thr_yield` set hands the pipeline to the next eligible thread. If the winning thread has `thr_hold` set, `sel_thread` names it and `sel_valid` is 0. A hold on a thread that does not win has no effect.
- R6: A signal adds one to the named semaphore. A wait on a non-zero semaphore subtracts one, and the waiting thread stays eligible.
- R7: A wait on a semaphore whose count is 0, with no signal to it in that cycle, parks the thread from the next edge on. A later signal to that semaphore releases the thread and consumes the signal, so the count stays 0.
- R8: Each hardware signal port `h` names its semaphore in bits `[h*SID_W +: SID_W]` of `hw_sig_sem`, and increments it in the same way as a software signal. All signals to one semaphore in one cycle add together.
- R9: A count never exceeds 2^SEM_W−1 (255 by default). Increments beyond that are dropped, and `sig_ovf` is 1 for the cycle after the one in which this happened.
- R10: A signal and a wait on the same semaphore in the same cycle leave its count unchanged, and the waiting thread is not parked. This holds even when the count is 0 or at its maximum, and in the latter case `sig_ovf` stays 0.
- R11: When several threads are parked on one semaphore, a single signal releases only the lowest-index waiter. The others stay parked until further signals arrive.
- R12: When no thread is eligible, `sel_valid` is 0 and `sel_thread` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | NUM_THREADS | Per-thread: thread has work to issue |
| thr_yield | input | NUM_THREADS | Per-thread: stalled on an operation that gives the pipeline away |
| thr_hold | input | NUM_THREADS | Per-thread: stalled without giving the pipeline away |
| wait_req | input | 1 | Software wait request this cycle |
| wait_thr | input | TID_W | Thread issuing the wait |
| wait_sem | input | SID_W | Semaphore the wait targets |
| sw_sig_req | input | 1 | Software signal request this cycle |
| sw_sig_sem | input | SID_W | Semaphore the software signal targets |
| hw_sig_req | input | NUM_HW_SIG | Per hardware agent: signal request |
| hw_sig_sem | input | NUM_HW_SIG*SID_W | Per hardware agent: target semaphore, agent h in bits [h*SID_W +: SID_W] |
| sel_thread | output | TID_W | Index of the thread owning the pipeline |
| sel_valid | output | 1 | The selected thread issues this cycle |
| sig_ovf | output | 1 | A saturated semaphore dropped a signal in the previous cycle |

## Verification
The assertions assume that a thread issues a wait only while it is not already parked, so each thread is parked on at most one semaphore at a time. They also assume that `wait_thr` and every semaphore index stay within the configured counts. The stimulus issues waits only from thread 7 (or from threads that are not yet parked) and uses in-range semaphore numbers. Counts are never read directly: the stimulus measures them by issuing waits until the thread parks and watching `sel_valid` fall. Saturation is reached by driving 255 consecutive signals to one semaphore.

// File: rtl/thsched_pkg.sv
`timescale 1ns/1ps
package thsched_pkg;

   // index width for a set of n items, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width of a counter that must hold values 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/thsched_prio_enc.sv
`timescale 1ns/1ps
module thsched_prio_enc #(
   parameter  int unsigned WIDTH = 8,
   localparam int unsigned IW    = thsched_pkg::idx_w(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx
);

   // lowest set bit wins; scan downwards so the last hit is the lowest index
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end

endmodule

// File: rtl/thsched_sem_cell.sv
`timescale 1ns/1ps
module thsched_sem_cell #(
   parameter  int unsigned NUM_THREADS = 8,
   parameter  int unsigned SEM_W       = 8,
   parameter  int unsigned INC_W       = 2,
   localparam int unsigned SUM_W       = SEM_W + INC_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [INC_W-1:0]       inc,
   input  logic [NUM_THREADS-1:0] want,
   output logic [NUM_THREADS-1:0] grant,
   output logic                   ovf
);

   localparam logic [SUM_W-1:0] CAP = SUM_W'((1 << SEM_W) - 1);

   logic [SEM_W-1:0]       cnt_q;
   logic [SUM_W-1:0]       avail;
   logic [SUM_W-1:0]       after;
   logic [NUM_THREADS-1:0] first;
   logic                   take;

   // one consumer per cycle: the lowest-index requester, if a unit exists
   always_comb begin
      first = want & (~want + NUM_THREADS'(1));
      avail = SUM_W'(cnt_q) + SUM_W'(inc);
      take  = (|want) && (avail != '0);
      grant = take ? first : '0;
      after = avail - SUM_W'(take);
      ovf   = after > CAP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= ovf ? CAP[SEM_W-1:0] : after[SEM_W-1:0];
   end

   assert_one_grant_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_sat_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == CAP[SEM_W-1:0]));

   assert_empty_stays_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((|want) && (cnt_q == '0) && (inc == '0)) |=> (cnt_q == '0));

   assert_pair_neutral_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      ((inc == INC_W'(1)) && (|want)) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/thsched_wait_table.sv
`timescale 1ns/1ps
module thsched_wait_table #(
   parameter  int unsigned NUM_THREADS = 8,
   parameter  int unsigned NUM_SEMS    = 16,
   localparam int unsigned TID_W       = thsched_pkg::idx_w(NUM_THREADS),
   localparam int unsigned SID_W       = thsched_pkg::idx_w(NUM_SEMS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wait_req,
   input  logic [TID_W-1:0]                wait_thr,
   input  logic [SID_W-1:0]                wait_sem,
   input  logic [NUM_THREADS-1:0]          grant_thr,
   output logic [NUM_SEMS*NUM_THREADS-1:0] want,
   output logic [NUM_THREADS-1:0]          parked_q,
   output logic [NUM_THREADS-1:0]          parked_d
);

   logic [NUM_THREADS-1:0][SID_W-1:0] psem_q;
   logic [NUM_THREADS-1:0]            fresh;

   always_comb begin
      for (int t = 0; t < NUM_THREADS; t++) begin
         fresh[t] = wait_req && (wait_thr == TID_W'(t));
      end
      for (int s = 0; s < NUM_SEMS; s++) begin
         for (int t = 0; t < NUM_THREADS; t++) begin
            want[s*NUM_THREADS + t] =
               (parked_q[t] && (psem_q[t] == SID_W'(s))) ||
               (fresh[t] && (wait_sem == SID_W'(s)));
         end
      end
      parked_d = (parked_q | fresh) & ~grant_thr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         parked_q <= '0;
         psem_q   <= '0;
      end else begin
         parked_q <= parked_d;
         for (int t = 0; t < NUM_THREADS; t++) begin
            if (fresh[t]) psem_q[t] <= wait_sem;
         end
      end
   end

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
      assert_park_cause_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(parked_q[t]) |-> $past(wait_req && (wait_thr == TID_W'(t))));

      assert_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         grant_thr[t] |=> !parked_q[t]);
   end

endmodule

// File: rtl/thread_sched.sv
`timescale 1ns/1ps
module thread_sched #(
   parameter  int unsigned NUM_THREADS = 8,
   parameter  int unsigned NUM_SEMS    = 16,
   parameter  int unsigned SEM_W       = 8,
   parameter  int unsigned NUM_HW_SIG  = 2,
   localparam int unsigned TID_W       = thsched_pkg::idx_w(NUM_THREADS),
   localparam int unsigned SID_W       = thsched_pkg::idx_w(NUM_SEMS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_THREADS-1:0]      thr_ready,
   input  logic [NUM_THREADS-1:0]      thr_yield,
   input  logic [NUM_THREADS-1:0]      thr_hold,
   input  logic                        wait_req,
   input  logic [TID_W-1:0]            wait_thr,
   input  logic [SID_W-1:0]            wait_sem,
   input  logic                        sw_sig_req,
   input  logic [SID_W-1:0]            sw_sig_sem,
   input  logic [NUM_HW_SIG-1:0]       hw_sig_req,
   input  logic [NUM_HW_SIG*SID_W-1:0] hw_sig_sem,
   output logic [TID_W-1:0]            sel_thread,
   output logic                        sel_valid,
   output logic                        sig_ovf
);

   localparam int unsigned NUM_SRC = NUM_HW_SIG + 1;
   localparam int unsigned INC_W   = thsched_pkg::cnt_w(NUM_SRC);

   // elaboration-time parameter checks
   if (NUM_THREADS < 2 || NUM_THREADS > 64) begin : g_bad_threads
      $error("thread_sched: NUM_THREADS must lie in 2..64");
   end
   if (NUM_SEMS < 1) begin : g_bad_sems
      $error("thread_sched: NUM_SEMS must be at least 1");
   end
   if (SEM_W < 2 || SEM_W > 16) begin : g_bad_semw
      $error("thread_sched: SEM_W must lie in 2..16");
   end
   if (NUM_HW_SIG < 1) begin : g_bad_hw
      $error("thread_sched: NUM_HW_SIG must be at least 1");
   end

   logic [NUM_SEMS-1:0][INC_W-1:0]       inc_s;
   logic [NUM_SEMS*NUM_THREADS-1:0]      want_flat;
   logic [NUM_SEMS-1:0][NUM_THREADS-1:0] grant_m;
   logic [NUM_SEMS-1:0]                  ovf_s;
   logic [NUM_THREADS-1:0]               grant_thr;
   logic [NUM_THREADS-1:0]               parked_q;
   logic [NUM_THREADS-1:0]               parked_d;
   logic [NUM_THREADS-1:0]               elig;
   logic                                 win_any;
   logic [TID_W-1:0]                     win_idx;
   logic [TID_W-1:0]                     sel_q;
   logic                                 valid_q;
   logic                                 ovf_q;

   // count how many signal sources land on each semaphore this cycle
   always_comb begin
      for (int s = 0; s < NUM_SEMS; s++) begin
         inc_s[s] = '0;
         if (sw_sig_req && (sw_sig_sem == SID_W'(s))) begin
            inc_s[s] = inc_s[s] + INC_W'(1);
         end
         for (int h = 0; h < NUM_HW_SIG; h++) begin
            if (hw_sig_req[h] && (hw_sig_sem[h*SID_W +: SID_W] == SID_W'(s))) begin
               inc_s[s] = inc_s[s] + INC_W'(1);
            end
         end
      end
   end

   thsched_wait_table #(
      .NUM_THREADS (NUM_THREADS),
      .NUM_SEMS    (NUM_SEMS)
   ) u_wait_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_req  (wait_req),
      .wait_thr  (wait_thr),
      .wait_sem  (wait_sem),
      .grant_thr (grant_thr),
      .want      (want_flat),
      .parked_q  (parked_q),
      .parked_d  (parked_d)
   );

   for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
      thsched_sem_cell #(
         .NUM_THREADS (NUM_THREADS),
         .SEM_W       (SEM_W),
         .INC_W       (INC_W)
      ) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_s[s]),
         .want  (want_flat[s*NUM_THREADS +: NUM_THREADS]),
         .grant (grant_m[s]),
         .ovf   (ovf_s[s])
      );
   end

   always_comb begin
      grant_thr = '0;
      for (int s = 0; s < NUM_SEMS; s++) begin
         grant_thr = grant_thr | grant_m[s];
      end
      // parked state after this edge, so a fresh park or release counts now
      elig = thr_ready & ~thr_yield & ~parked_d;
   end

   thsched_prio_enc #(
      .WIDTH (NUM_THREADS)
   ) u_pick (
      .req (elig),
      .any (win_any),
      .idx (win_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= '0;
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (win_any) sel_q <= win_idx;
         valid_q <= win_any && !thr_hold[win_idx];
         ovf_q   <= |ovf_s;
      end
   end

   assign sel_thread = sel_q;
   assign sel_valid  = valid_q;
   assign sig_ovf    = ovf_q;

   assert_no_parked_issue_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> !parked_q[sel_thread]);

   assert_idle_keeps_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid && !$past(sel_valid) && $stable(thr_ready) |-> $stable(sel_thread) || $past(|thr_hold));

endmodule

// File: tb/thread_sched_bench.sv
`timescale 1ns/1ps
module thread_sched_bench;

   localparam int NT  = 8;
   localparam int NS  = 16;
   localparam int NHW = 2;
   localparam int TW  = 3;
   localparam int SW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NT-1:0]   thr_ready = '0;
   logic [NT-1:0]   thr_yield = '0;
   logic [NT-1:0]   thr_hold = '0;
   logic            wait_req = 1'b0;
   logic [TW-1:0]   wait_thr = '0;
   logic [SW-1:0]   wait_sem = '0;
   logic            sw_sig_req = 1'b0;
   logic [SW-1:0]   sw_sig_sem = '0;
   logic [NHW-1:0]  hw_sig_req = '0;
   logic [NHW*SW-1:0] hw_sig_sem = '0;
   logic [TW-1:0]   sel_thread;
   logic            sel_valid;
   logic            sig_ovf;

   always #2 clk = ~clk;

   thread_sched u_thread_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_ready  (thr_ready),
      .thr_yield  (thr_yield),
      .thr_hold   (thr_hold),
      .wait_req   (wait_req),
      .wait_thr   (wait_thr),
      .wait_sem   (wait_sem),
      .sw_sig_req (sw_sig_req),
      .sw_sig_sem (sw_sig_sem),
      .hw_sig_req (hw_sig_req),
      .hw_sig_sem (hw_sig_sem),
      .sel_thread (sel_thread),
      .sel_valid  (sel_valid),
      .sig_ovf    (sig_ovf)
   );

   typedef struct {
      bit    chk_sel;
      bit    v;
      int    th;
      bit    chk_ovf;
      bit    o;
      string req;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   task automatic note(input bit ok, input string req, input string what,
                       input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: results of the edge just taken, sampled 1 ns later
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         if (e.chk_sel) begin
            note(sel_valid == e.v, e.req, "sel_valid", int'(sel_valid), int'(e.v));
            if (e.th >= 0)
               note(int'(sel_thread) == e.th, e.req, "sel_thread", int'(sel_thread), e.th);
         end
         if (e.chk_ovf)
            note(sig_ovf == e.o, e.req, "sig_ovf", int'(sig_ovf), int'(e.o));
      end
   end

   // driver: inputs already set after a negedge; queue the expectation
   task automatic tick(input bit cs, input bit v, input int th,
                       input bit co, input bit o, input string req);
      exp_t x;
      x.chk_sel = cs; x.v = v; x.th = th; x.chk_ovf = co; x.o = o; x.req = req;
      q.push_back(x);
      @(negedge clk);
      wait_req   = 1'b0;
      sw_sig_req = 1'b0;
      hw_sig_req = '0;
   endtask

   task automatic sig(input int s);
      sw_sig_req = 1'b1;
      sw_sig_sem = SW'(s);
   endtask

   task automatic wt(input int t, input int s);
      wait_req = 1'b1;
      wait_thr = TW'(t);
      wait_sem = SW'(s);
   endtask

   task automatic hsig(input int h, input int s);
      hw_sig_req[h] = 1'b1;
      hw_sig_sem[h*SW +: SW] = SW'(s);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      note(sel_valid == 1'b0, "R1", "sel_valid in reset", int'(sel_valid), 0);
      note(sel_thread == '0, "R1", "sel_thread in reset", int'(sel_thread), 0);
      note(sig_ovf == 1'b0, "R1", "sig_ovf in reset", int'(sig_ovf), 0);
      rst_n = 1'b1;
      tick(1, 0, 0, 1, 0, "R1");

      // R2: lowest eligible index wins
      thr_ready = 8'hA0;
      tick(1, 1, 5, 0, 0, "R2");
      thr_ready = 8'hFF;
      tick(1, 1, 0, 0, 0, "R2");

      // R3/R4: pre-emption shows only after the edge
      thr_ready = 8'h40;
      tick(1, 1, 6, 0, 0, "R4");
      thr_ready = 8'h44;
      #1;
      note(int'(sel_thread) == 6, "R3", "sel_thread before edge", int'(sel_thread), 6);
      tick(1, 1, 2, 0, 0, "R4");

      // R5: yield gives way, hold keeps ownership without issue
      thr_ready = 8'h05;
      thr_yield = 8'h01;
      tick(1, 1, 2, 0, 0, "R5");
      thr_yield = 8'h00;
      thr_hold  = 8'h01;
      tick(1, 0, 0, 0, 0, "R5");
      thr_hold  = 8'h04;
      tick(1, 1, 0, 0, 0, "R5");
      thr_hold  = 8'h00;

      // R12: nothing eligible keeps last index
      thr_ready = 8'h08;
      tick(1, 1, 3, 0, 0, "R12");
      thr_ready = 8'h00;
      tick(1, 0, 3, 0, 0, "R12");

      // R6/R7: count semaphore 1 with thread 7
      thr_ready = 8'h80;
      sig(1);  tick(1, 1, 7, 0, 0, "R6");
      sig(1);  tick(1, 1, 7, 0, 0, "R6");
      wt(7, 1); tick(1, 1, 7, 0, 0, "R6");
      wt(7, 1); tick(1, 1, 7, 0, 0, "R6");
      wt(7, 1); tick(1, 0, 7, 0, 0, "R7");
      tick(1, 0, 7, 0, 0, "R7");
      sig(1);  tick(1, 1, 7, 0, 0, "R7");
      wt(7, 1); tick(1, 0, 7, 0, 0, "R7");
      hsig(1, 1); tick(1, 1, 7, 0, 0, "R8");

      // R8: three sources in one cycle add up to three
      sig(2); hsig(0, 2); hsig(1, 2);
      tick(1, 1, 7, 1, 0, "R8");
      for (int i = 0; i < 3; i++) begin
         wt(7, 2); tick(1, 1, 7, 0, 0, "R8");
      end
      wt(7, 2); tick(1, 0, 7, 0, 0, "R8");
      hsig(0, 2); tick(1, 1, 7, 0, 0, "R8");

      // R10: signal and wait together on an empty semaphore
      sig(3); wt(7, 3); tick(1, 1, 7, 0, 0, "R10");
      wt(7, 3); tick(1, 0, 7, 0, 0, "R10");
      sig(3); tick(1, 1, 7, 0, 0, "R10");

      // R11: two waiters, lowest index released first
      thr_ready = 8'hA8;
      wt(3, 4); tick(1, 1, 5, 0, 0, "R11");
      wt(5, 4); tick(1, 1, 7, 0, 0, "R11");
      sig(4);  tick(1, 1, 3, 0, 0, "R11");
      thr_ready = 8'hA0;
      tick(1, 1, 7, 0, 0, "R11");
      sig(4);  tick(1, 1, 5, 0, 0, "R11");

      // R9: saturation of semaphore 9
      thr_ready = 8'h80;
      for (int i = 0; i < 255; i++) begin
         sig(9); tick(0, 0, -1, 1, 0, "R9");
      end
      sig(9); tick(0, 0, -1, 1, 1, "R9");
      tick(0, 0, -1, 1, 0, "R9");
      sig(9); hsig(0, 9); tick(0, 0, -1, 1, 1, "R9");
      sig(9); wt(7, 9); tick(1, 1, 7, 1, 0, "R10");
      for (int i = 0; i < 255; i++) begin
         wt(7, 9); tick(1, 1, 7, 0, 0, "R9");
      end
      wt(7, 9); tick(1, 0, 7, 0, 0, "R9");
      sig(9); tick(1, 1, 7, 1, 0, "R9");

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule